// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects a set of level-sensitive peripheral interrupt lines and presents them to a small group of processors. Each processor owns one request output and one private register window. A shared global window holds a control register that reports how many sources exist, a pair of index-written registers that turn a source's global enable on or off, one routing register per source selecting which processors may see it, and a doorbell trigger that lets software post inter-processor notifications. The private window holds an index-written mask-on/mask-off pair, a doorbell cause register, and an acknowledge register. Reading the acknowledge register returns the number of the source that currently wins for that processor.

All accesses travel over one simple register bus. Address bit 12 picks the window (0 global, 1 private), and `cpu_sel` names the processor making the access. Reads are combinational and have no side effect. Writes take effect at the next rising clock edge. Selection is fixed-priority. A pending doorbell (code 0) beats every peripheral. Among peripherals, the lowest-numbered eligible source wins. Code 1023 means nothing is pending. One source number is reserved as a processor-local source: it ignores the global enable and the routing bits, and only each processor's own mask gates it.

Top module: `mcirq_ctrl`

## Requirements
- R1: After reset every global enable is 0, every routing bit is 0 and every processor mask bit is 1, so each acknowledge reads 1023, every request is low, and routing registers read 0.
- R2: A read of global offset 0x000 returns NUM_SRC in bits [11:2] and zero in all other bits.
- R3: Writing a source number to global offset 0x030 sets its enable, and writing it to 0x034 clears it. A written value of NUM_SRC or more (any bit of [31:10] set, or [9:0] ≥ NUM_SRC) changes nothing.
- R4: Writing a source number to private offset 0x048 masks that source for the processor on `cpu_sel` only. Writing it to 0x04C unmasks it for that processor only. Out-of-range values are ignored.
- R5: The routing register of source n is at global offset 0x100 + 4·n. Bit c (c < NUM_CPU) lets source n reach processor c. It reads back the stored bits.
- R6: Sources are level sensitive. A source is eligible for processor c exactly while its input is high, it is unmasked for c, and (except for the local source) it is enabled and routed to c. Reading the acknowledge register changes no state.
- R7: Private offset 0x044 returns in bits [9:0] the lowest-numbered eligible source, or 1023 when none is eligible. Upper bits read 0.
- R8: Source PCPU_SRC (default 5) ignores global enable and routing. It is eligible for processor c when its input is high and it is unmasked for c.
- R9: A write to global offset 0x004 sets doorbell bit wdata[2:0] in the cause register of every processor c with wdata[8+c] = 1. Private offset 0x008 reads that processor's 8 cause bits, and any write there clears them all. While any cause bit is set, that processor's acknowledge reads 0, ahead of all peripherals.
- R10: irq_out[c] is high exactly when processor c's acknowledge value differs from 1023.
- R11: Input line 0 is never reported, because code 0 is reserved for doorbells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Level interrupt inputs, one per source |
| cpu_sel | input | CPU_W | Processor issuing the access |
| addr | input | ADDR_W | Byte address; bit 12 selects the private window |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq_out | output | NUM_CPU | Request line per processor |

## Verification
Two things can fall in the same cycle: a doorbell posted to a processor, and a peripheral source that becomes eligible for that same processor. The bench raises a routed, enabled, unmasked peripheral line and then posts a doorbell to the same processor while the line stays high. The acknowledge must read 0 while the cause is set, and it must fall back to the peripheral number on the cycle after the cause is cleared. A random phase mixes doorbell writes, mask changes and input toggles cycle by cycle. Each cycle the bench compares the request lines and the read data with a behavioural model.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam logic [11:0] OFF_CTRL    = 12'h000;
  localparam logic [11:0] OFF_DB_TRIG = 12'h004;
  localparam logic [11:0] OFF_DB_CAUSE= 12'h008;
  localparam logic [11:0] OFF_EN_SET  = 12'h030;
  localparam logic [11:0] OFF_EN_CLR  = 12'h034;
  localparam logic [11:0] OFF_ACK     = 12'h044;
  localparam logic [11:0] OFF_MSK_SET = 12'h048;
  localparam logic [11:0] OFF_MSK_CLR = 12'h04C;
  localparam logic [9:0]  ROUTE_WORD0 = 10'h040;
  localparam logic [9:0]  ACK_NONE    = 10'h3FF;
  localparam logic [9:0]  ACK_DBELL   = 10'h000;
  localparam int          DB_CNT      = 8;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic route_wr;
    logic db_trig;
    logic msk_set;
    logic msk_clr;
    logic db_clr;
  } ic_wcmd_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTRL,
    RD_ROUTE,
    RD_ACK,
    RD_CAUSE
  } ic_rd_e;
endpackage

// File: rtl/ic_decode.sv
module ic_decode
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 13,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output ic_wcmd_t          wcmd,
  output ic_rd_e            rd_kind,
  output logic [SRC_W-1:0]  route_idx
);
  localparam logic [9:0] ROUTE_END = ROUTE_WORD0 + 10'(NUM_SRC);

  logic        priv_win;
  logic [11:0] off;
  logic        route_hit;
  logic [9:0]  word;

  always_comb begin
    priv_win  = addr[ADDR_W-1];
    off       = addr[11:0];
    word      = off[11:2];
    route_hit = !priv_win && (word >= ROUTE_WORD0) && (word < ROUTE_END);
    route_idx = SRC_W'(word - ROUTE_WORD0);

    wcmd          = '0;
    wcmd.en_set   = we && !priv_win && (off == OFF_EN_SET);
    wcmd.en_clr   = we && !priv_win && (off == OFF_EN_CLR);
    wcmd.db_trig  = we && !priv_win && (off == OFF_DB_TRIG);
    wcmd.route_wr = we && route_hit;
    wcmd.msk_set  = we && priv_win && (off == OFF_MSK_SET);
    wcmd.msk_clr  = we && priv_win && (off == OFF_MSK_CLR);
    wcmd.db_clr   = we && priv_win && (off == OFF_DB_CAUSE);

    rd_kind = RD_ZERO;
    if (priv_win) begin
      if (off == OFF_ACK)           rd_kind = RD_ACK;
      else if (off == OFF_DB_CAUSE) rd_kind = RD_CAUSE;
    end else begin
      if (off == OFF_CTRL)          rd_kind = RD_CTRL;
      else if (route_hit)           rd_kind = RD_ROUTE;
    end
  end
endmodule

// File: rtl/ic_src_bank.sv
module ic_src_bank #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en_set,
  input  logic                              en_clr,
  input  logic                              widx_ok,
  input  logic [SRC_W-1:0]                  widx,
  input  logic                              route_wr,
  input  logic [SRC_W-1:0]                  route_idx,
  input  logic [NUM_CPU-1:0]                route_data,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q
);
  logic [NUM_SRC-1:0]              en_d;
  logic                            en_upd;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_d;

  always_comb begin
    en_d   = en_q;
    en_upd = widx_ok && (en_set || en_clr);
    if (en_set) en_d[widx] = 1'b1;
    if (en_clr) en_d[widx] = 1'b0;
    route_d = route_q;
    route_d[route_idx] = route_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
    end else if (route_wr) begin
      route_q <= route_d;
    end
  end
endmodule

// File: rtl/ic_cpu_slice.sv
module ic_cpu_slice
  import ic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int PCPU_SRC = 5,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               msk_set,
  input  logic               msk_clr,
  input  logic               widx_ok,
  input  logic [SRC_W-1:0]   widx,
  input  logic               db_trig,
  input  logic [2:0]         db_num,
  input  logic               db_clr,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] route_col,
  output logic [9:0]         ack,
  output logic               req,
  output logic [DB_CNT-1:0]  cause
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_upd;
  logic [DB_CNT-1:0]  cause_d;
  logic               cause_upd;
  logic [NUM_SRC-1:0] elig;
  logic [9:0]         pick;

  // next-state for mask and doorbell cause
  always_comb begin
    mask_d   = mask_q;
    mask_upd = sel && widx_ok && (msk_set || msk_clr);
    if (msk_set) mask_d[widx] = 1'b1;
    if (msk_clr) mask_d[widx] = 1'b0;

    cause_d   = cause;
    cause_upd = (sel && db_clr) || db_trig;
    if (sel && db_clr) cause_d = '0;
    if (db_trig)       cause_d[db_num] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_upd) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
    end else if (cause_upd) begin
      cause <= cause_d;
    end
  end

  // eligibility: line 0 is reserved for the doorbell code
  always_comb begin
    elig = '0;
    for (int n = 1; n < NUM_SRC; n++) begin
      if (n == PCPU_SRC) elig[n] = irq_in[n] && !mask_q[n];
      else               elig[n] = irq_in[n] && !mask_q[n] && en_q[n] && route_col[n];
    end
  end

  // fixed priority: scan downward so the lowest index is left last
  always_comb begin
    pick = ACK_NONE;
    for (int n = NUM_SRC - 1; n >= 1; n--) begin
      if (elig[n]) pick = 10'(n);
    end
    ack = (|cause) ? ACK_DBELL : pick;
    req = (ack != ACK_NONE);
  end
endmodule

// File: rtl/mcirq_ctrl.sv
module mcirq_ctrl
  import ic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  parameter int ADDR_W   = 13,
  parameter int PCPU_SRC = 5,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [CPU_W-1:0]   cpu_sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_CPU-1:0] irq_out
);
  ic_wcmd_t                        wcmd;
  ic_rd_e                          rd_kind;
  logic [SRC_W-1:0]                route_idx;
  logic [SRC_W-1:0]                widx;
  logic                            widx_ok;
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] route_t;
  logic [NUM_CPU-1:0][9:0]         ack_all;
  logic [NUM_CPU-1:0][DB_CNT-1:0]  cause_all;

  ic_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .addr      (addr),
    .we        (we),
    .wcmd      (wcmd),
    .rd_kind   (rd_kind),
    .route_idx (route_idx)
  );

  always_comb begin
    widx_ok = (wdata[31:10] == '0) && (wdata[9:0] < 10'(NUM_SRC));
    widx    = wdata[SRC_W-1:0];
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int n = 0; n < NUM_SRC; n++) route_t[c][n] = route_q[n][c];
    end
  end

  ic_src_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (wcmd.en_set),
    .en_clr     (wcmd.en_clr),
    .widx_ok    (widx_ok),
    .widx       (widx),
    .route_wr   (wcmd.route_wr),
    .route_idx  (route_idx),
    .route_data (wdata[NUM_CPU-1:0]),
    .en_q       (en_q),
    .route_q    (route_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    ic_cpu_slice #(.NUM_SRC(NUM_SRC), .PCPU_SRC(PCPU_SRC)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (cpu_sel == CPU_W'(c)),
      .msk_set   (wcmd.msk_set),
      .msk_clr   (wcmd.msk_clr),
      .widx_ok   (widx_ok),
      .widx      (widx),
      .db_trig   (wcmd.db_trig && wdata[8+c]),
      .db_num    (wdata[2:0]),
      .db_clr    (wcmd.db_clr),
      .irq_in    (irq_in),
      .en_q      (en_q),
      .route_col (route_t[c]),
      .ack       (ack_all[c]),
      .req       (irq_out[c]),
      .cause     (cause_all[c])
    );
  end

  always_comb begin
    rdata = '0;
    unique case (rd_kind)
      RD_CTRL:  rdata[11:2] = 10'(NUM_SRC);
      RD_ROUTE: rdata[NUM_CPU-1:0] = route_q[route_idx];
      RD_ACK:   if (int'(cpu_sel) < NUM_CPU) rdata[9:0] = ack_all[cpu_sel];
      RD_CAUSE: if (int'(cpu_sel) < NUM_CPU) rdata[DB_CNT-1:0] = cause_all[cpu_sel];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/mcirq_ctrl_chk.sv
module mcirq_ctrl_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  parameter int ADDR_W   = 13,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic [CPU_W-1:0]   cpu_sel,
  input logic [ADDR_W-1:0]  addr,
  input logic               we,
  input logic [31:0]        wdata,
  input logic [31:0]        rdata,
  input logic [NUM_CPU-1:0] irq_out
);
  logic rd_ctrl, rd_ack;
  assign rd_ctrl = !addr[ADDR_W-1] && (addr[11:0] == 12'h000);
  assign rd_ack  =  addr[ADDR_W-1] && (addr[11:0] == 12'h044);

  // R2: control register reports the source count
  a_r2_ctrl_count: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (rdata[11:2] == 10'(NUM_SRC)));

  // R10: request line agrees with the acknowledge code
  a_r10_req_vs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && int'(cpu_sel) < NUM_CPU) |->
      (irq_out[cpu_sel] == (rdata[9:0] != 10'h3FF)));

  // R6: no write and steady inputs leave requests unchanged (reads are side-effect free)
  a_r6_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(irq_in) |-> $stable(irq_out)));

  // R9: a posted doorbell raises the targeted request on the next cycle
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_db
    a_r9_doorbell_req: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !addr[ADDR_W-1] && addr[11:0] == 12'h004 && wdata[8+c]) |=> irq_out[c]);
  end
endmodule

bind mcirq_ctrl mcirq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_in  (irq_in),
  .cpu_sel (cpu_sel),
  .addr    (addr),
  .we      (we),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_out (irq_out)
);

// File: tb/sim_mcirq_ctrl.sv
`timescale 1ns/1ps
module sim_mcirq_ctrl;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int LOCAL_SRC = 5;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] irq_in;
  logic [1:0]    cpu_sel;
  logic [12:0]   addr;
  logic          we;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NC-1:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  bit m_en    [NS];
  bit m_route [NS][NC];
  bit m_msk   [NC][NS];
  bit m_cause [NC][8];

  mcirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_sel(cpu_sel),
    .addr(addr), .we(we), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int model_ack(int c);
    for (int b = 0; b < 8; b++) if (m_cause[c][b]) return 0;
    for (int n = 1; n < NS; n++) begin
      if (irq_in[n] && !m_msk[c][n] && (n == LOCAL_SRC || (m_en[n] && m_route[n][c])))
        return n;
    end
    return 1023;
  endfunction

  function automatic logic [31:0] model_rd(logic [12:0] a, int c);
    logic [31:0] r;
    int w;
    r = '0;
    w = int'(a[11:2]);
    if (!a[12]) begin
      if (a[11:0] == 12'h000) r = 32'(NS) << 2;
      else if (w >= 64 && w < 64 + NS)
        for (int k = 0; k < NC; k++) r[k] = m_route[w-64][k];
    end else begin
      if (a[11:0] == 12'h044) r = 32'(model_ack(c));
      else if (a[11:0] == 12'h008)
        for (int b = 0; b < 8; b++) r[b] = m_cause[c][b];
    end
    return r;
  endfunction

  task automatic model_wr(logic [12:0] a, int c, logic [31:0] d);
    bit ok;
    int w;
    int i;
    ok = (d[31:10] == 0) && (d[9:0] < NS);
    i  = int'(d[9:0]);
    w  = int'(a[11:2]);
    if (!a[12]) begin
      if (a[11:0] == 12'h030 && ok) m_en[i] = 1;
      if (a[11:0] == 12'h034 && ok) m_en[i] = 0;
      if (a[11:0] == 12'h004)
        for (int k = 0; k < NC; k++) if (d[8+k]) m_cause[k][d[2:0]] = 1;
      if (w >= 64 && w < 64 + NS)
        for (int k = 0; k < NC; k++) m_route[w-64][k] = d[k];
    end else begin
      if (a[11:0] == 12'h048 && ok) m_msk[c][i] = 1;
      if (a[11:0] == 12'h04C && ok) m_msk[c][i] = 0;
      if (a[11:0] == 12'h008)
        for (int b = 0; b < 8; b++) m_cause[c][b] = 0;
    end
  endtask

  // one bus cycle: drive at negedge, compare before the edge, update model at the edge
  task automatic step(logic [12:0] a, bit w, logic [31:0] d, int c,
                      logic [NS-1:0] irq, string tag);
    logic [NC-1:0] exp_req;
    logic [31:0]   exp_rd;
    @(negedge clk);
    addr = a; we = w; wdata = d; cpu_sel = 2'(c); irq_in = irq;
    #1;
    for (int k = 0; k < NC; k++) exp_req[k] = (model_ack(k) != 1023);
    exp_rd = model_rd(a, c);
    n_cmp++;
    if (irq_out !== exp_req) begin
      n_bad++;
      $display("FAIL %s R10 irq_out actual=%b expected=%b", tag, irq_out, exp_req);
    end
    n_cmp++;
    if (rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata addr=%h cpu=%0d actual=%h expected=%h", tag, a, c, rdata, exp_rd);
    end
    @(posedge clk);
    if (w) model_wr(a, c, d);
  endtask

  localparam logic [12:0] P = 13'h1000;

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NS-1:0] lv;
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; cpu_sel = '0; irq_in = '0;
    for (int n = 0; n < NS; n++) begin
      m_en[n] = 0;
      for (int k = 0; k < NC; k++) begin m_route[n][k] = 0; m_msk[k][n] = 1; end
    end
    for (int k = 0; k < NC; k++) for (int b = 0; b < 8; b++) m_cause[k][b] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: all lines high but everything masked after reset
    for (int c = 0; c < NC; c++) step(P | 13'h044, 0, 0, c, '1, "R1");
    step(13'h10C, 0, 0, 0, '1, "R1 route");
    // R2
    step(13'h000, 0, 0, 0, '0, "R2");
    // R5/R3/R4: route src 3 to cpu0, enable, unmask on cpu0 and cpu1
    lv = '0; lv[3] = 1'b1;
    step(13'h10C, 1, 32'h1, 0, lv, "R5 write");
    step(13'h030, 1, 32'd3, 0, lv, "R3 set");
    step(P | 13'h04C, 1, 32'd3, 0, lv, "R4 unmask c0");
    step(P | 13'h04C, 1, 32'd3, 1, lv, "R4 unmask c1");
    step(P | 13'h044, 0, 0, 0, lv, "R7 ack c0");
    step(P | 13'h044, 0, 0, 1, lv, "R5 unrouted c1");
    step(13'h10C, 0, 0, 0, lv, "R5 readback");
    // R6: level behaviour, repeated reads
    step(P | 13'h044, 0, 0, 0, '0, "R6 low");
    step(P | 13'h044, 0, 0, 0, lv, "R6 high");
    step(P | 13'h044, 0, 0, 0, lv, "R6 reread");
    // R7: lowest wins
    lv[7] = 1'b1;
    step(13'h11C, 1, 32'h3, 0, lv, "R5 route7");
    step(13'h030, 1, 32'd7, 0, lv, "R3 set7");
    step(P | 13'h04C, 1, 32'd7, 0, lv, "R4 unmask7 c0");
    step(P | 13'h04C, 1, 32'd7, 1, lv, "R4 unmask7 c1");
    step(P | 13'h044, 0, 0, 0, lv, "R7 both");
    lv[3] = 1'b0;
    step(P | 13'h044, 0, 0, 0, lv, "R7 next");
    lv[3] = 1'b1;
    // R3: clear enable and an out-of-range write
    step(13'h034, 1, 32'd3, 0, lv, "R3 clear");
    step(P | 13'h044, 0, 0, 0, lv, "R3 cleared");
    step(13'h030, 1, 32'd35, 0, lv, "R3 range");
    step(13'h030, 1, 32'h403, 0, lv, "R3 upper");
    step(P | 13'h044, 0, 0, 0, lv, "R3 ignored");
    // R4: cpu1 masks 7, cpu0 unaffected
    step(P | 13'h048, 1, 32'd7, 1, lv, "R4 mask c1");
    step(P | 13'h044, 0, 0, 1, lv, "R4 c1 quiet");
    step(P | 13'h044, 0, 0, 0, lv, "R4 c0 still");
    // R8: local source on cpu2
    lv[LOCAL_SRC] = 1'b1;
    step(P | 13'h04C, 1, 32'd5, 2, lv, "R8 unmask");
    step(P | 13'h044, 0, 0, 2, lv, "R8 ack c2");
    step(P | 13'h044, 0, 0, 3, lv, "R8 c3 masked");
    // R9: doorbell vs peripheral on cpu0, also to cpu2
    step(13'h004, 1, 32'h0503, 0, lv, "R9 trig");
    step(P | 13'h044, 0, 0, 0, lv, "R9 wins c0");
    step(P | 13'h044, 0, 0, 2, lv, "R9 wins c2");
    step(P | 13'h008, 0, 0, 0, lv, "R9 cause");
    step(P | 13'h008, 1, 32'h0, 0, lv, "R9 clear");
    step(P | 13'h044, 0, 0, 0, lv, "R9 back c0");
    step(P | 13'h044, 0, 0, 2, lv, "R9 c2 kept");
    step(P | 13'h008, 1, 32'h0, 2, lv, "R9 clear c2");
    // R11: line 0 never reported
    lv = '0; lv[0] = 1'b1;
    step(13'h100, 1, 32'h8, 0, lv, "R11 route");
    step(13'h030, 1, 32'd0, 0, lv, "R11 en");
    step(P | 13'h04C, 1, 32'd0, 3, lv, "R11 unmask");
    step(P | 13'h044, 0, 0, 3, lv, "R11 quiet");

    // mixed random traffic
    for (int t = 0; t < 600; t++) begin
      logic [12:0] a;
      logic [31:0] d;
      bit w;
      int c;
      c = int'($urandom % NC);
      d = 32'($urandom % 40);
      w = ($urandom % 3) != 0;
      case ($urandom % 9)
        0: a = 13'h000;
        1: begin a = 13'(13'h100 + 4 * ($urandom % NS)); d = 32'($urandom % 16); end
        2: a = 13'h030;
        3: a = 13'h034;
        4: begin a = 13'h004; d = {20'h0, 4'($urandom), 5'h0, 3'($urandom)}; w = ($urandom % 4) == 0; end
        5: a = P | 13'h044;
        6: a = P | 13'h048;
        7: a = P | 13'h04C;
        default: a = P | 13'h008;
      endcase
      step(a, w, d, c, NS'({$urandom} & $urandom), "R6 R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule